// File: doc/BRIEF.md
# I2C Master START Recovery Controller

This block is the START-generation front end of an I2C master that can get itself out of a hung bus. Software sets a start request and, optionally, a stop request through a small register write port. The block watches the sampled SDA and SCL lines and an external bus-busy indication, and drives open-drain pull-down enables for both lines. When the start request can go ahead, it puts a START condition on the wire, loads status code 0x08 and raises its interrupt.

Two hang-up cases are handled without software. If the bus reports busy for too long, software can set the stop request while the start request is still pending. The block then treats the bus as free without putting a STOP on the wire, clears the stop request itself and proceeds to a START. If another device holds SDA low, the block clocks SCL with a programmable half period and samples SDA again after every second pulse, until SDA is released. It then sends an ordinary START. A repeated START, issued while the block already owns the bus, uses the same recovery. A held-low SCL cannot be resolved, so the block just waits.

Top module: `i2c_start_recover`

## Requirements
- R1: After reset both pull-down enables are 0, the interrupt is 0, both request flags read 0 and the status code reads 0xF8.
- R2: A register write with `wr_start` = 1 sets the start flag, with `wr_stop` = 1 sets the stop flag, and with `wr_irq_clr` = 1 clears the interrupt and returns the status to 0xF8. The flags are readable on `start_flag` and `stop_flag`.
- R3: While idle with a start request pending, `bus_busy` = 1 and no stop request, the block leaves both lines released and raises no interrupt.
- R4: A stop request set while a start request is pending and the bus is busy is cleared by hardware within three cycles of the write. No STOP condition (SDA released while SCL is high) is placed on the wire, and a START follows.
- R5: A START holds SDA low with SCL released for `half_period` cycles, after SDA and SCL have both been seen high for `half_period` cycles. It then pulls SCL low with SDA still low, sets the status to 0x08, raises the interrupt and clears the start flag. SDA is only ever pulled low while SCL is high.
- R6: If SDA is low at the sampling point, the block issues SCL pulses of `half_period` cycles low and `half_period` cycles high, with SDA released. It samples SDA after every second pulse, so a device that frees SDA during pulse k (k >= 1) leads to the smallest even number of pulses that is at least k.
- R7: A start request written while the bus is owned after a START first releases SDA with SCL held low for `half_period` cycles. It then follows R5 and R6, so the repeated START recovers from a low SDA in the same way.
- R8: While SCL is held low by another device, the block generates no pulses and no START, keeps the start flag set, and resumes once SCL is freed. A high phase is only counted while SCL reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_start | input | 1 | Write data: set start request |
| wr_stop | input | 1 | Write data: set stop request |
| wr_irq_clr | input | 1 | Write data: clear interrupt and status |
| half_period | input | HP_W | SCL half period in clock cycles (at least 1) |
| bus_busy | input | 1 | Bus-busy indication from the bus monitor |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_flag | output | 1 | Start request readback |
| stop_flag | output | 1 | Stop request readback |
| status | output | 8 | Status code (0xF8 none, 0x08 START sent) |
| irq | output | 1 | Interrupt, set when a START completes |

## Verification
A sequencer stuck in the wrong state shows up either as a wrong pulse count before the interrupt or as an SDA edge while SCL is high at the wrong moment. The pulse count should be even and at least the release pulse, and the edge would be a false START or STOP. Both are visible within one or two half periods of the faulty transition. A wrong sampling parity shifts the pulse count by one whole pulse. A wrong half-period count changes the measured START hold and low-phase totals at the first phase boundary. A stop flag that hardware fails to clear can be read back three cycles after the forcing write.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_START,
        ST_OWN,
        ST_REL,
        ST_PLOW,
        ST_PHIGH
    } sr_state_e;

    typedef struct packed {
        logic sda_oe;
        logic scl_oe;
    } line_drv_t;

    localparam logic [7:0] STAT_NONE    = 8'hF8;
    localparam logic [7:0] STAT_STARTED = 8'h08;

    function automatic line_drv_t drive_for(sr_state_e s);
        line_drv_t d;
        d = '{sda_oe: 1'b0, scl_oe: 1'b0};
        case (s)
            ST_START: d.sda_oe = 1'b1;
            ST_OWN:   d = '{sda_oe: 1'b1, scl_oe: 1'b1};
            ST_REL:   d.scl_oe = 1'b1;
            ST_PLOW:  d.scl_oe = 1'b1;
            default:  d = '{sda_oe: 1'b0, scl_oe: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sr_half_timer.sv
module sr_half_timer #(
    parameter int HP_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            run,
    input  logic [HP_W-1:0] half,
    output logic            done
);
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] last;

    assign last = half - {{(HP_W-1){1'b0}}, 1'b1};
    assign done = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || done)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sr_req_flags.sv
module sr_req_flags
    import i2c_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_start,
    input  logic       wr_stop,
    input  logic       wr_irq_clr,
    input  logic       start_done,
    input  logic       force_take,
    output logic       start_flag,
    output logic       stop_flag,
    output logic       irq,
    output logic [7:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
            irq        <= 1'b0;
            status     <= STAT_NONE;
        end else begin
            if (wr_en && wr_start)
                start_flag <= 1'b1;
            else if (start_done)
                start_flag <= 1'b0;

            if (wr_en && wr_stop)
                stop_flag <= 1'b1;
            else if (force_take)
                stop_flag <= 1'b0;

            if (start_done) begin
                irq    <= 1'b1;
                status <= STAT_STARTED;
            end else if (wr_en && wr_irq_clr) begin
                irq    <= 1'b0;
                status <= STAT_NONE;
            end
        end
    end
endmodule

// File: rtl/sr_seq.sv
module sr_seq
    import i2c_sr_pkg::*;
#(
    parameter int PULSES_PER_TRY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_flag,
    input  logic      stop_flag,
    input  logic      bus_busy,
    input  logic      sda_in,
    input  logic      scl_in,
    input  logic      tmr_done,
    output sr_state_e st,
    output logic      tmr_run,
    output logic      tmr_restart,
    output logic      start_done,
    output logic      force_take,
    output line_drv_t drv
);
    localparam int PC_W = $clog2(PULSES_PER_TRY + 1);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSES_PER_TRY - 1);

    sr_state_e       nxt;
    logic [PC_W-1:0] pcnt;

    always_comb begin
        nxt        = st;
        tmr_run    = 1'b0;
        start_done = 1'b0;
        force_take = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start_flag) begin
                    if (!bus_busy) begin
                        nxt = ST_SETUP;
                    end else if (stop_flag) begin
                        force_take = 1'b1;
                        nxt        = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                tmr_run = scl_in;
                if (tmr_done) nxt = sda_in ? ST_START : ST_PLOW;
            end
            ST_START: begin
                tmr_run = scl_in;
                if (tmr_done) begin
                    start_done = 1'b1;
                    nxt        = ST_OWN;
                end
            end
            ST_OWN: begin
                if (start_flag) nxt = ST_REL;
            end
            ST_REL: begin
                tmr_run = 1'b1;
                if (tmr_done) nxt = ST_SETUP;
            end
            ST_PLOW: begin
                tmr_run = 1'b1;
                if (tmr_done) nxt = ST_PHIGH;
            end
            ST_PHIGH: begin
                tmr_run = scl_in;
                if (tmr_done) begin
                    if (pcnt == PC_LAST) nxt = sda_in ? ST_START : ST_PLOW;
                    else                 nxt = ST_PLOW;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign tmr_restart = (nxt != st);
    assign drv         = drive_for(st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            pcnt <= '0;
        end else begin
            st <= nxt;
            if (st != ST_PHIGH && nxt == ST_SETUP)
                pcnt <= '0;
            else if (st == ST_PHIGH && tmr_done)
                pcnt <= (pcnt == PC_LAST) ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_start_recover.sv
module i2c_start_recover
    import i2c_sr_pkg::*;
#(
    parameter int HP_W           = 16,
    parameter int PULSES_PER_TRY = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_start,
    input  logic            wr_stop,
    input  logic            wr_irq_clr,
    input  logic [HP_W-1:0] half_period,
    input  logic            bus_busy,
    input  logic            sda_in,
    input  logic            scl_in,
    output logic            sda_oe,
    output logic            scl_oe,
    output logic            start_flag,
    output logic            stop_flag,
    output logic [7:0]      status,
    output logic            irq
);
    sr_state_e st;
    line_drv_t drv;
    logic      tmr_run;
    logic      tmr_restart;
    logic      tmr_done;
    logic      start_done;
    logic      force_take;

    sr_req_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_start   (wr_start),
        .wr_stop    (wr_stop),
        .wr_irq_clr (wr_irq_clr),
        .start_done (start_done),
        .force_take (force_take),
        .start_flag (start_flag),
        .stop_flag  (stop_flag),
        .irq        (irq),
        .status     (status)
    );

    sr_half_timer #(.HP_W(HP_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .run     (tmr_run),
        .half    (half_period),
        .done    (tmr_done)
    );

    sr_seq #(.PULSES_PER_TRY(PULSES_PER_TRY)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_flag  (start_flag),
        .stop_flag   (stop_flag),
        .bus_busy    (bus_busy),
        .sda_in      (sda_in),
        .scl_in      (scl_in),
        .tmr_done    (tmr_done),
        .st          (st),
        .tmr_run     (tmr_run),
        .tmr_restart (tmr_restart),
        .start_done  (start_done),
        .force_take  (force_take),
        .drv         (drv)
    );

    assign sda_oe = drv.sda_oe;
    assign scl_oe = drv.scl_oe;
endmodule

// File: rtl/i2c_start_recover_chk.sv
module i2c_start_recover_chk
    import i2c_sr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_start,
    input logic       wr_stop,
    input logic       bus_busy,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       start_flag,
    input logic       stop_flag,
    input logic [7:0] status,
    input logic       irq,
    input sr_state_e  st
);
    // R2
    start_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_start) |=> start_flag);

    // R3
    busy_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_flag && !stop_flag && bus_busy) |=> (st == ST_IDLE && !sda_oe));

    // R4
    force_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_flag && stop_flag && bus_busy && !(wr_en && wr_stop)) |=> !stop_flag);

    // R5
    start_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status == STAT_STARTED));

    // R5
    start_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> scl_in);

    // R8
    scl_stuck_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_in |=> !$rose(sda_oe));
endmodule

bind i2c_start_recover i2c_start_recover_chk u_chk (.*);

// File: tb/test_i2c_start_recover.sv
module test_i2c_start_recover;
    localparam int HP_W = 16;
    localparam int HALF = 4;
    localparam int NVEC = 5;
    // each row: pulse during which the device frees SDA, expected pulse count
    localparam int VEC [NVEC][2] = '{'{0, 0}, '{1, 2}, '{2, 2}, '{3, 4}, '{5, 6}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_start = 1'b0, wr_stop = 1'b0, wr_irq_clr = 1'b0;
    logic bus_busy = 1'b0;
    logic dev_sda_low = 1'b0, dev_scl_low = 1'b0;
    logic sda_oe, scl_oe, start_flag, stop_flag, irq;
    logic [7:0] status;
    logic sda_in, scl_in;

    assign sda_in = ~sda_oe & ~dev_sda_low;
    assign scl_in = ~scl_oe & ~dev_scl_low;

    always #2.5 clk = ~clk;

    i2c_start_recover #(.HP_W(HP_W)) i_i2c_start_recover (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_start(wr_start), .wr_stop(wr_stop),
        .wr_irq_clr(wr_irq_clr), .half_period(HP_W'(HALF)), .bus_busy(bus_busy),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .start_flag(start_flag), .stop_flag(stop_flag), .status(status), .irq(irq)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // bus observers, sampled on the falling edge
    int pulses = 0, low_cyc = 0, start_cyc = 0, stop_ev = 0, bad_start = 0;
    int release_at = 0;
    bit hold_active = 1'b0;
    logic p_scl_oe = 1'b0, p_sda_oe = 1'b0;

    always @(negedge clk) begin
        if (scl_oe && !p_scl_oe && !irq) pulses++;
        if (scl_oe && !sda_oe) low_cyc++;
        if (sda_oe && !scl_oe) start_cyc++;
        if (!sda_oe && p_sda_oe && scl_in) stop_ev++;
        if (sda_oe && !p_sda_oe && !scl_in) bad_start++;
        if (hold_active && pulses >= release_at) begin
            dev_sda_low <= 1'b0;
            hold_active <= 1'b0;
        end
        p_scl_oe <= scl_oe;
        p_sda_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        pulses = 0; low_cyc = 0; start_cyc = 0; stop_ev = 0; bad_start = 0;
    endtask

    task automatic reg_write(input logic s, input logic p, input logic c);
        @(negedge clk);
        wr_en = 1'b1; wr_start = s; wr_stop = p; wr_irq_clr = c;
        @(negedge clk);
        wr_en = 1'b0; wr_start = 1'b0; wr_stop = 1'b0; wr_irq_clr = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output bit got);
        got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bit got;
        do_reset();
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 irq", irq, 0);
        chk("R1 flags", {start_flag, stop_flag}, 0);
        chk("R1 status", status, 8'hF8);

        // R3 busy bus, no stop request: wait
        bus_busy = 1'b1;
        clear_obs();
        reg_write(1'b1, 1'b0, 1'b0);
        chk("R2 start flag set", start_flag, 1);
        repeat (50) @(negedge clk);
        chk("R3 no irq while busy", irq, 0);
        chk("R3 lines released", {sda_oe, scl_oe, low_cyc[0]}, 0);

        // R5 bus frees: normal START
        bus_busy = 1'b0;
        wait_irq(100, got);
        chk("R5 irq raised", got, 1);
        chk("R5 status", status, 8'h08);
        chk("R5 start flag cleared", start_flag, 0);
        chk("R5 start hold cycles", start_cyc, HALF);
        chk("R5 no pulses", pulses, 0);
        chk("R5 SDA edge with SCL high", bad_start, 0);
        @(negedge clk);
        chk("R5 owned lines", {sda_oe, scl_oe}, 2'b11);
        reg_write(1'b0, 1'b0, 1'b1);
        chk("R2 irq clear", {irq, status}, {1'b0, 8'hF8});

        // R4 forced access on a busy bus
        do_reset();
        bus_busy = 1'b1;
        clear_obs();
        reg_write(1'b1, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        reg_write(1'b0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R4 stop flag cleared by hardware", stop_flag, 0);
        wait_irq(100, got);
        chk("R4 START after forced access", got, 1);
        chk("R4 no STOP on wire", stop_ev, 0);
        chk("R4 status", status, 8'h08);
        reg_write(1'b0, 1'b0, 1'b1);

        // R6 R7 stuck SDA recovery on repeated starts, from the vector table
        for (int v = 0; v < NVEC; v++) begin
            clear_obs();
            release_at = VEC[v][0];
            if (VEC[v][0] > 0) begin
                dev_sda_low = 1'b1;
                hold_active = 1'b1;
            end
            reg_write(1'b1, 1'b0, 1'b0);
            wait_irq(400, got);
            chk("R7 repeated START done", got, 1);
            chk("R6 pulse count", pulses, VEC[v][1]);
            chk("R6 low phase cycles", low_cyc, (VEC[v][1] + 1) * HALF);
            chk("R5 SDA edge with SCL high", bad_start, 0);
            reg_write(1'b0, 1'b0, 1'b1);
        end

        // R8 SCL held low: no recovery attempted
        clear_obs();
        dev_scl_low = 1'b1;
        reg_write(1'b1, 1'b0, 1'b0);
        repeat (200) @(negedge clk);
        chk("R8 no irq with SCL stuck", irq, 0);
        chk("R8 start flag kept", start_flag, 1);
        chk("R8 no pulses", {pulses, sda_oe}, 0);
        dev_scl_low = 1'b0;
        wait_irq(100, got);
        chk("R8 resumes after SCL freed", got, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule